// File: doc/BRIEF.md
# Windowed Bidirectional Step Shift Register

This block keeps a bank of single-bit relay flags and moves the contents of one contiguous stretch of that bank by one place each time a level pulse input turns on. The stretch, called the window, starts at a head index and runs for a given number of bits toward higher indices. Bits outside the window belong to other users of the bank, and this block never alters them.

A step is taken only when the pulse input is seen high on a clock after it was seen low on the clock before. A pulse that stays high does not cause a second step. In forward mode the serial data bit enters the window at its head, and the other bits move toward the far end. In reverse mode the data bit enters at the far end, and the other bits move toward the head. A synchronous clear input zeroes the window, and it wins over a step in the same cycle. Whether the asynchronous power-on reset also clears the bank is set by a build-time retention option.

Top module: `win_shift_reg`

## Requirements
- R1: With retention off (RETAIN=0), while rst_n is low all bits of bits_o read 0 and the pulse history is low. With retention on, rst_n clears only the pulse history.
- R2: A step happens on a clock where pulse is 1 and pulse was 0 at the previous clock, or where pulse is 1 at the first clock after reset. If pulse stays at 1 over later clocks, no further step happens.
- R3: Forward step (dir_rev=0): each window bit at index i>head_idx takes the old value of bit i-1, and bit head_idx takes din.
- R4: Reverse step (dir_rev=1): each window bit at index i<head_idx+bit_cnt-1 takes the old value of bit i+1, and bit head_idx+bit_cnt-1 takes din.
- R5: With clr=1 on a clock and a valid window, every window bit becomes 0. This wins over a step on the same clock.
- R6: Bits with an index outside [head_idx, head_idx+bit_cnt-1] never change through a step or a clear.
- R7: The window is invalid when bit_cnt is 0 or head_idx+bit_cnt exceeds ARRAY_BITS. cfg_err_o is then 1, and neither a step nor a clear changes any bit.
- R8: head_bit_o shows bits_o[head_idx] and tail_bit_o shows bits_o[head_idx+bit_cnt-1]. Both read 0 while the window is invalid.
- R9: With bit_cnt=1, a step in either direction loads din into bit head_idx and changes nothing else.
- R10: The pulse history is updated on every clock, including clocks with clr=1 or an invalid window. A rising edge taken during a clear or an invalid window is therefore used up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| clr | input | 1 | Synchronous clear of the window |
| pulse | input | 1 | Level step request, acts on its rising edge |
| din | input | 1 | Serial bit entering the window on a step |
| dir_rev | input | 1 | 0 = forward (away from head), 1 = reverse (toward head) |
| head_idx | input | $clog2(ARRAY_BITS) | Index of the window head bit |
| bit_cnt | input | $clog2(ARRAY_BITS+1) | Window length in bits |
| bits_o | output | ARRAY_BITS | Full bank contents |
| head_bit_o | output | 1 | Current value of the head bit |
| tail_bit_o | output | 1 | Current value of the last window bit |
| cfg_err_o | output | 1 | Window configuration is invalid |

## Verification
The bench targets a pulse held high across many clocks and an edge that arrives together with clr. A design that steps on level instead of edge would keep shifting in the first case, and one that gates the pulse history with clr would take a late step in the second. Windows at index 0, at the top end of the bank, spanning the whole bank and one bit long check the boundary neighbours: an off-by-one there would corrupt a bit just outside the window or pull in a stray neighbour. Windows that are too long and zero-length windows must leave the bank frozen, so a missing range check would show up as changed bits.

// File: rtl/win_shift_pkg.sv
package win_shift_pkg;
    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_REV = 1'b1
    } shift_dir_e;
endpackage

// File: rtl/win_pulse_edge.sv
module win_pulse_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = pulse;
        rise_o = pulse & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/win_window_decode.sv
module win_window_decode #(
    parameter int ARRAY_BITS = 128,
    localparam int IDX_W = $clog2(ARRAY_BITS),
    localparam int CNT_W = $clog2(ARRAY_BITS + 1),
    localparam int SUM_W = CNT_W + 1
) (
    input  logic [IDX_W-1:0]      head_idx,
    input  logic [CNT_W-1:0]      bit_cnt,
    output logic [ARRAY_BITS-1:0] in_win_o,
    output logic [ARRAY_BITS-1:0] is_head_o,
    output logic [ARRAY_BITS-1:0] is_last_o,
    output logic [IDX_W-1:0]      last_idx_o,
    output logic                  cfg_ok_o
);
    logic [SUM_W-1:0] head_x, end_x, last_x;

    always_comb begin
        head_x     = SUM_W'(head_idx);
        end_x      = head_x + SUM_W'(bit_cnt);
        last_x     = end_x - SUM_W'(1);
        cfg_ok_o   = (bit_cnt != '0) && (end_x <= SUM_W'(ARRAY_BITS));
        last_idx_o = last_x[IDX_W-1:0];
    end

    for (genvar i = 0; i < ARRAY_BITS; i++) begin : g_bit
        always_comb begin
            in_win_o[i]  = cfg_ok_o && (SUM_W'(i) >= head_x) && (SUM_W'(i) < end_x);
            is_head_o[i] = cfg_ok_o && (SUM_W'(i) == head_x);
            is_last_o[i] = cfg_ok_o && (SUM_W'(i) == last_x);
        end
    end
endmodule

// File: rtl/win_shift_next.sv
module win_shift_next
    import win_shift_pkg::*;
#(
    parameter int ARRAY_BITS = 128
) (
    input  logic [ARRAY_BITS-1:0] cur_i,
    input  logic [ARRAY_BITS-1:0] in_win_i,
    input  logic [ARRAY_BITS-1:0] is_head_i,
    input  logic [ARRAY_BITS-1:0] is_last_i,
    input  logic                  step_i,
    input  logic                  clr_i,
    input  shift_dir_e            dir_i,
    input  logic                  din_i,
    output logic [ARRAY_BITS-1:0] nxt_o
);
    for (genvar i = 0; i < ARRAY_BITS; i++) begin : g_bit
        logic lower_nb, upper_nb;
        if (i == 0) begin : g_lo_edge
            assign lower_nb = din_i;
        end else begin : g_lo_mid
            assign lower_nb = cur_i[i-1];
        end
        if (i == ARRAY_BITS - 1) begin : g_hi_edge
            assign upper_nb = din_i;
        end else begin : g_hi_mid
            assign upper_nb = cur_i[i+1];
        end

        always_comb begin
            nxt_o[i] = cur_i[i];
            if (in_win_i[i]) begin
                if (clr_i) begin
                    nxt_o[i] = 1'b0;
                end else if (step_i) begin
                    if (dir_i == DIR_FWD) nxt_o[i] = is_head_i[i] ? din_i : lower_nb;
                    else                  nxt_o[i] = is_last_i[i] ? din_i : upper_nb;
                end
            end
        end
    end
endmodule

// File: rtl/win_shift_reg.sv
module win_shift_reg
    import win_shift_pkg::*;
#(
    parameter int ARRAY_BITS = 128,
    parameter bit RETAIN     = 1'b0,
    localparam int IDX_W = $clog2(ARRAY_BITS),
    localparam int CNT_W = $clog2(ARRAY_BITS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  pulse,
    input  logic                  din,
    input  logic                  dir_rev,
    input  logic [IDX_W-1:0]      head_idx,
    input  logic [CNT_W-1:0]      bit_cnt,
    output logic [ARRAY_BITS-1:0] bits_o,
    output logic                  head_bit_o,
    output logic                  tail_bit_o,
    output logic                  cfg_err_o
);
    typedef struct packed {
        logic [ARRAY_BITS-1:0] bits;
    } state_t;

    state_t st_d, st_q;

    logic                  rise;
    logic [ARRAY_BITS-1:0] in_win, is_head, is_last, nxt_bits;
    logic [IDX_W-1:0]      last_idx;
    logic                  cfg_ok;
    shift_dir_e            dir;

    assign dir = shift_dir_e'(dir_rev);

    win_pulse_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pulse  (pulse),
        .rise_o (rise)
    );

    win_window_decode #(.ARRAY_BITS(ARRAY_BITS)) u_dec (
        .head_idx   (head_idx),
        .bit_cnt    (bit_cnt),
        .in_win_o   (in_win),
        .is_head_o  (is_head),
        .is_last_o  (is_last),
        .last_idx_o (last_idx),
        .cfg_ok_o   (cfg_ok)
    );

    win_shift_next #(.ARRAY_BITS(ARRAY_BITS)) u_next (
        .cur_i     (st_q.bits),
        .in_win_i  (in_win),
        .is_head_i (is_head),
        .is_last_i (is_last),
        .step_i    (rise),
        .clr_i     (clr),
        .dir_i     (dir),
        .din_i     (din),
        .nxt_o     (nxt_bits)
    );

    always_comb begin
        st_d      = st_q;
        st_d.bits = nxt_bits;
    end

    if (RETAIN) begin : g_keep
        always_ff @(posedge clk) begin
            st_q <= st_d;
        end
    end else begin : g_wipe
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end
    end

    always_comb begin
        bits_o     = st_q.bits;
        cfg_err_o  = ~cfg_ok;
        head_bit_o = cfg_ok ? st_q.bits[head_idx] : 1'b0;
        tail_bit_o = cfg_ok ? st_q.bits[last_idx] : 1'b0;
    end
endmodule

// File: rtl/win_shift_reg_chk.sv
module win_shift_reg_chk #(
    parameter int ARRAY_BITS = 128,
    parameter bit RETAIN     = 1'b0,
    localparam int IDX_W = $clog2(ARRAY_BITS),
    localparam int CNT_W = $clog2(ARRAY_BITS + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  clr,
    input logic                  pulse,
    input logic                  din,
    input logic                  dir_rev,
    input logic [IDX_W-1:0]      head_idx,
    input logic [CNT_W-1:0]      bit_cnt,
    input logic [ARRAY_BITS-1:0] bits_o,
    input logic                  head_bit_o,
    input logic                  tail_bit_o,
    input logic                  cfg_err_o
);
    logic seen_q, armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            seen_q  <= pulse;
            armed_q <= 1'b1;
        end
    end

    logic rise_c;
    assign rise_c = pulse && !seen_q;

    AST_HELD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && pulse && !clr) |=> $stable(bits_o)); // R2

    AST_FWD_HEAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_c && !dir_rev && !clr && !cfg_err_o) |=>
        ((head_bit_o == $past(din)) || !$stable(head_idx) || !$stable(bit_cnt))); // R3

    AST_REV_TAIL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_c && dir_rev && !clr && !cfg_err_o) |=>
        ((tail_bit_o == $past(din)) || !$stable(head_idx) || !$stable(bit_cnt))); // R4

    AST_CLEAR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !cfg_err_o) |=>
        ((!head_bit_o && !tail_bit_o) || !$stable(head_idx) || !$stable(bit_cnt))); // R5

    AST_BAD_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |=> $stable(bits_o)); // R7

    AST_BAD_CFG_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> (!head_bit_o && !tail_bit_o)); // R8

    if (!RETAIN) begin : g_por
        AST_POR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            !armed_q |-> (bits_o == '0)); // R1
    end
endmodule

bind win_shift_reg win_shift_reg_chk #(.ARRAY_BITS(ARRAY_BITS), .RETAIN(RETAIN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .pulse      (pulse),
    .din        (din),
    .dir_rev    (dir_rev),
    .head_idx   (head_idx),
    .bit_cnt    (bit_cnt),
    .bits_o     (bits_o),
    .head_bit_o (head_bit_o),
    .tail_bit_o (tail_bit_o),
    .cfg_err_o  (cfg_err_o)
);

// File: tb/win_shift_reg_tb.sv
module win_shift_reg_tb;
    localparam int  N     = 128;
    localparam int  IDX_W = $clog2(N);
    localparam int  CNT_W = $clog2(N + 1);
    localparam time TCLK  = 10ns;

    logic clk = 1'b0;
    logic rst_n, clr, pulse, din, dir_rev;
    logic [IDX_W-1:0] head_idx;
    logic [CNT_W-1:0] bit_cnt;
    logic [N-1:0] bits_o;
    logic head_bit_o, tail_bit_o, cfg_err_o;

    always #(TCLK/2) clk = ~clk;

    win_shift_reg #(.ARRAY_BITS(N), .RETAIN(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .pulse(pulse), .din(din),
        .dir_rev(dir_rev), .head_idx(head_idx), .bit_cnt(bit_cnt),
        .bits_o(bits_o), .head_bit_o(head_bit_o), .tail_bit_o(tail_bit_o),
        .cfg_err_o(cfg_err_o)
    );

    int    n_chk = 0, n_bad = 0;
    bit    done  = 0;
    string tag   = "R1";
    logic [N-1:0] m_bits;
    logic  m_prev;

    task automatic chk(input bit ok, input string t, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    function automatic bit cfg_valid();
        return (int'(bit_cnt) >= 1) && (int'(head_idx) + int'(bit_cnt) <= N);
    endfunction

    task automatic model_step();
        int h = int'(head_idx);
        int l = int'(head_idx) + int'(bit_cnt) - 1;
        bit rise;
        if (!rst_n) begin
            m_bits = '0;
            m_prev = 1'b0;
            return;
        end
        rise   = pulse && !m_prev;
        m_prev = pulse;
        if (!cfg_valid()) return;
        if (clr) begin
            for (int i = h; i <= l; i++) m_bits[i] = 1'b0;
        end else if (rise) begin
            if (!dir_rev) begin
                for (int i = l; i > h; i--) m_bits[i] = m_bits[i-1];
                m_bits[h] = din;
            end else begin
                for (int i = h; i < l; i++) m_bits[i] = m_bits[i+1];
                m_bits[l] = din;
            end
        end
    endtask

    task automatic compare();
        logic eh, et;
        eh = cfg_valid() ? m_bits[int'(head_idx)] : 1'b0;
        et = cfg_valid() ? m_bits[int'(head_idx) + int'(bit_cnt) - 1] : 1'b0;
        chk(bits_o === m_bits, {tag, " bank"}, bits_o, m_bits);
        chk({head_bit_o, tail_bit_o} === {eh, et}, "R8 ends",
            N'({head_bit_o, tail_bit_o}), N'({eh, et}));
        chk(cfg_err_o === !cfg_valid(), "R7 cfg_err", N'(cfg_err_o), N'(!cfg_valid()));
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic push(input logic d);
        din = d; pulse = 1'b1; tick();
        pulse = 1'b0; tick();
    endtask

    task automatic set_win(input int h, input int c);
        head_idx = IDX_W'(h);
        bit_cnt  = CNT_W'(c);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; clr = 0; pulse = 0; din = 0; dir_rev = 0;
        set_win(10, 8);
        m_bits = '0; m_prev = 0;
        @(negedge clk);
        tag = "R1"; tick(); tick();
        rst_n = 1'b1; tick();
        chk(bits_o === '0, "R1 reset bank", bits_o, '0);

        // R3 forward pushes 1,0,1,1 into window 10..17
        tag = "R3";
        push(1); push(0); push(1); push(1);
        chk(bits_o[13:10] === 4'b1011, "R3 fwd order", N'(bits_o[13:10]), N'(4'b1011));
        chk(bits_o[9:0] === '0 && bits_o[N-1:18] === '0, "R6 outside fwd", bits_o, m_bits);

        // R2 held pulse: one step only
        tag = "R2";
        din = 1; pulse = 1; tick();
        din = 0; repeat (5) tick();
        chk(bits_o[14:10] === 5'b10111, "R2 held pulse single step",
            N'(bits_o[14:10]), N'(5'b10111));
        pulse = 0; tick();

        // R4 reverse: din enters bit 17, contents move toward 10
        tag = "R4"; dir_rev = 1;
        push(1); push(1);
        chk(bits_o[17:16] === 2'b11, "R4 rev tail load", N'(bits_o[17:16]), N'(2'b11));
        chk(bits_o[11:10] === 2'b01, "R4 rev toward head", N'(bits_o[11:10]), N'(2'b01));

        // R5 clear wins over edge; R10 the edge is used up
        tag = "R5";
        clr = 1; pulse = 1; din = 1; tick();
        chk(bits_o[17:10] === '0, "R5 clear priority", N'(bits_o[17:10]), '0);
        tag = "R10";
        clr = 0; tick(); tick();
        chk(bits_o[17:10] === '0, "R10 edge consumed by clear", N'(bits_o[17:10]), '0);
        pulse = 0; tick();

        // R7 invalid windows
        tag = "R7";
        set_win(125, 5); push(1); clr = 1; tick(); clr = 0;
        set_win(3, 0); push(1);
        chk(cfg_err_o === 1'b1, "R7 zero length flagged", N'(cfg_err_o), N'(1));

        // boundary windows, R6 outside untouched
        tag = "R6";
        dir_rev = 0; set_win(120, 8);
        push(1); push(1); push(0);
        dir_rev = 1; push(1);
        set_win(0, N); dir_rev = 0;
        push(1); push(0); dir_rev = 1; push(1);
        set_win(0, 4); push(1); push(0);

        // R9 length-one window
        tag = "R9";
        set_win(64, 1); dir_rev = 0; push(1);
        chk(bits_o[64] === 1'b1, "R9 single fwd", N'(bits_o[64]), N'(1));
        dir_rev = 1; push(0);
        chk(bits_o[64] === 1'b0, "R9 single rev", N'(bits_o[64]), N'(0));

        // random traffic
        tag = "R6";
        for (int k = 0; k < 3000; k++) begin
            if (($urandom % 40) == 0) set_win($urandom % N, $urandom % (N + 1));
            if (($urandom % 8) == 0)  set_win($urandom % N, 1 + ($urandom % 16));
            pulse   = $urandom % 2;
            din     = $urandom % 2;
            dir_rev = (($urandom % 4) == 0);
            clr     = (($urandom % 25) == 0);
            tick();
        end
        clr = 0; pulse = 0;

        // R1 asynchronous reset mid-run
        tag = "R1";
        set_win(0, N); push(1);
        rst_n = 0; tick();
        chk(bits_o === '0, "R1 async clear", bits_o, '0);
        pulse = 1; rst_n = 1;
        tag = "R2"; tick();
        chk(bits_o[0] === 1'b1, "R2 first clock after reset steps", N'(bits_o[0]), N'(1));
        pulse = 0; tick();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule